// File: doc/BRIEF.md
# Pipeline Bubble and Drain Controller

This block owns the validity bits of a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. Each cycle a bit set to 1 marks its stage as a bubble and a bit at 0 marks real work. The bits move down the pipe one stage per cycle. Three events change that flow.

- A stall request from the hazard unit holds the front of the pipe and slips a bubble into execute.
- A branch that decode resolves as taken squashes the instruction fetched behind it. Fetch goes on from the target.
- A halt seen by fetch shuts the front of the pipe for good, and the older work then drains out.

The block also produces the program-counter write enable and the hold for the fetch-to-decode register. Its all-idle output tells a test harness when the pipe has emptied after a halt. It handles no datapath values.

Top module: `pipe_bubble_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `if_nop` is 0 and `id_nop`, `ex_nop`, `mem_nop` and `wb_nop` are all 1.
- R2: In a cycle with no effective stall, branch or halt, each of `id_nop`, `ex_nop`, `mem_nop` and `wb_nop` takes the value the stage before it held one cycle earlier, and `if_nop` keeps its value.
- R3: A halt taken in cycle N sets `if_nop` and `id_nop` to 1 in cycle N+1, and both stay at 1 until reset.
- R4: After a halt taken in cycle N, `ex_nop` is 1 from cycle N+2, `mem_nop` from N+3 and `wb_nop` from N+4.
- R5: A taken branch while `id_nop` is 0 keeps `pc_we` at 1 and `ifid_hold` at 0 in that cycle. In the next cycle `id_nop` is 1 and `if_nop` is 0.
- R6: A stall request while `id_nop` is 0 drives `pc_we` to 0 and `ifid_hold` to 1 in that cycle. In the next cycle `if_nop` and `id_nop` are unchanged and `ex_nop` is 1.
- R7: When a taken branch and a stall request arrive together while `id_nop` is 0, the branch wins: `pc_we` is 1, `ifid_hold` is 0, and the next cycle follows R5.
- R8: A stall request or taken branch while `id_nop` is 1 has no effect: the cycle behaves as R2 describes.
- R9: `halt_fetched` is acted on only when `if_nop` is 0 and the same cycle holds neither an effective stall nor an effective taken branch. Otherwise it has no effect.
- R10: `all_idle` is 1 exactly when all five nop outputs are 1.
- R11: `pc_we` is 0 while `if_nop` is 1 and in the cycle a halt is taken. It is 1 in every other cycle without an effective stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halt_fetched | input | 1 | Fetch holds a halt instruction this cycle |
| branch_taken | input | 1 | Decode resolved its branch as taken this cycle |
| stall_req | input | 1 | Hazard unit asks for a one-cycle stall of decode |
| if_nop | output | 1 | Fetch stage is a bubble |
| id_nop | output | 1 | Decode stage is a bubble |
| ex_nop | output | 1 | Execute stage is a bubble |
| mem_nop | output | 1 | Memory stage is a bubble |
| wb_nop | output | 1 | Writeback stage is a bubble |
| pc_we | output | 1 | Program counter may update this cycle |
| ifid_hold | output | 1 | Fetch-to-decode register keeps its value this cycle |
| all_idle | output | 1 | Every stage is a bubble |

## Verification
The bench goes after the cases where events collide or arrive while decode is already a bubble. A design with the wrong priority would freeze the PC on a branch that comes with a stall and lose the redirect. A design without gating on decode validity would put stray bubbles into execute after a squash. A halt that arrives in the same cycle as a stall or a wrong-path branch must be dropped. If it were taken, the pipe would shut one instruction early. The drain timing after a halt is checked stage by stage, so a chain that is off by one cycle shows up as a wrong nop bit at N+2, N+3 or N+4.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  // Stages behind decode: execute, memory, writeback
  localparam int BACK_STAGES = 3;
  localparam int EX_IDX  = 0;
  localparam int MEM_IDX = 1;
  localparam int WB_IDX  = 2;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_STALL  = 2'd1,
    EV_BRANCH = 2'd2,
    EV_HALT   = 2'd3
  } pipe_event_t;
endpackage

// File: rtl/pbc_arbiter.sv
module pbc_arbiter
  import pbc_pkg::*;
(
  input  logic        if_nop,
  input  logic        id_nop,
  input  logic        halt_fetched,
  input  logic        branch_taken,
  input  logic        stall_req,
  output pipe_event_t ev,
  output logic        pc_we,
  output logic        ifid_hold,
  output logic        ex_bubble
);
  logic br_go, st_go, halt_go;

  // Priority: branch over stall over halt; decode events need a valid decode
  always_comb begin
    br_go   = branch_taken && !id_nop;
    st_go   = stall_req && !id_nop && !br_go;
    halt_go = halt_fetched && !if_nop && !br_go && !st_go;
    if (br_go)        ev = EV_BRANCH;
    else if (st_go)   ev = EV_STALL;
    else if (halt_go) ev = EV_HALT;
    else              ev = EV_NONE;
  end

  assign pc_we     = !if_nop && !st_go && !halt_go;
  assign ifid_hold = st_go;
  assign ex_bubble = st_go;

  always_comb begin
    a_onehot_ev_r7: assert ($onehot0({br_go, st_go, halt_go}));
  end
endmodule

// File: rtl/pbc_front.sv
module pbc_front
  import pbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  pipe_event_t ev,
  output logic        if_nop,
  output logic        id_nop
);
  logic if_d, id_d;

  always_comb begin
    if_d = if_nop;
    id_d = if_nop;
    case (ev)
      EV_HALT:   begin if_d = 1'b1; id_d = 1'b1; end
      EV_BRANCH: id_d = 1'b1;
      EV_STALL:  id_d = id_nop;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if_nop <= 1'b0;
      id_nop <= 1'b1;
    end else begin
      if_nop <= if_d;
      id_nop <= id_d;
    end
  end

  p_if_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    if_nop |=> if_nop);
  p_halt_front_r3: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_HALT) |=> (if_nop && id_nop));
  p_stall_front_r6: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_STALL) |=> ($stable(if_nop) && !id_nop));
endmodule

// File: rtl/pbc_drain.sv
module pbc_drain #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_nop,
  output logic [DEPTH-1:0] nop_q
);
  always_ff @(posedge clk) begin
    if (rst) nop_q[0] <= 1'b1;
    else     nop_q[0] <= in_nop;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) nop_q[i] <= 1'b1;
      else     nop_q[i] <= nop_q[i-1];
    end
  end

  p_tail_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (&nop_q && in_nop) |=> (&nop_q));
endmodule

// File: rtl/pipe_bubble_ctrl.sv
module pipe_bubble_ctrl
  import pbc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic halt_fetched,
  input  logic branch_taken,
  input  logic stall_req,
  output logic if_nop,
  output logic id_nop,
  output logic ex_nop,
  output logic mem_nop,
  output logic wb_nop,
  output logic pc_we,
  output logic ifid_hold,
  output logic all_idle
);
  pipe_event_t            ev;
  logic                   ex_bubble;
  logic [BACK_STAGES-1:0] back_nop;

  pbc_arbiter u_arb (
    .if_nop       (if_nop),
    .id_nop       (id_nop),
    .halt_fetched (halt_fetched),
    .branch_taken (branch_taken),
    .stall_req    (stall_req),
    .ev           (ev),
    .pc_we        (pc_we),
    .ifid_hold    (ifid_hold),
    .ex_bubble    (ex_bubble)
  );

  pbc_front u_front (
    .clk    (clk),
    .rst    (rst),
    .ev     (ev),
    .if_nop (if_nop),
    .id_nop (id_nop)
  );

  pbc_drain #(.DEPTH(BACK_STAGES)) u_drain (
    .clk    (clk),
    .rst    (rst),
    .in_nop (id_nop | ex_bubble),
    .nop_q  (back_nop)
  );

  assign ex_nop   = back_nop[EX_IDX];
  assign mem_nop  = back_nop[MEM_IDX];
  assign wb_nop   = back_nop[WB_IDX];
  assign all_idle = if_nop & id_nop & (&back_nop);

  p_halt_ex_r4: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_HALT) |=> ##1 ex_nop);
  p_halt_mem_r4: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_HALT) |=> ##2 mem_nop);
  p_halt_wb_r4: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_HALT) |=> ##3 wb_nop);
  p_branch_squash_r5: assert property (@(posedge clk) disable iff (rst)
    (branch_taken && !id_nop) |=> (id_nop && !if_nop));
  p_stall_bubble_r6: assert property (@(posedge clk) disable iff (rst)
    (stall_req && !branch_taken && !id_nop) |=> ex_nop);
  p_stall_ctl_r6: assert property (@(posedge clk) disable iff (rst)
    (stall_req && !branch_taken && !id_nop) |-> (!pc_we && ifid_hold));
  p_branch_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (branch_taken && stall_req && !id_nop) |-> (pc_we && !ifid_hold));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    all_idle |=> all_idle);
  p_pc_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    if_nop |-> !pc_we);
endmodule

// File: tb/pipe_bubble_ctrl_test.sv
`timescale 1ns/1ps
module pipe_bubble_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_fetched = 1'b0, branch_taken = 1'b0, stall_req = 1'b0;
  logic if_nop, id_nop, ex_nop, mem_nop, wb_nop, pc_we, ifid_hold, all_idle;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pipe_bubble_ctrl uut (
    .clk(clk), .rst(rst), .halt_fetched(halt_fetched), .branch_taken(branch_taken),
    .stall_req(stall_req), .if_nop(if_nop), .id_nop(id_nop), .ex_nop(ex_nop),
    .mem_nop(mem_nop), .wb_nop(wb_nop), .pc_we(pc_we), .ifid_hold(ifid_hold),
    .all_idle(all_idle)
  );

  // {halt, branch, stall, if, id, ex, mem, wb, pc_we, hold, idle}
  localparam int NVEC = 14;
  localparam logic [10:0] VEC [NVEC] = '{
    11'b000_01111_100,  // 0 reset state
    11'b000_00111_100,  // 1 flow
    11'b001_00011_010,  // 2 stall
    11'b000_00101_100,  // 3 bubble in ex
    11'b010_00010_100,  // 4 branch taken
    11'b001_01001_100,  // 5 stall while decode squashed
    11'b011_00100_100,  // 6 branch + stall
    11'b000_01010_100,  // 7 after priority branch
    11'b100_00101_000,  // 8 halt fetched (N)
    11'b000_11010_000,  // 9 N+1
    11'b000_11101_000,  // 10 N+2
    11'b000_11110_000,  // 11 N+3
    11'b111_11111_001,  // 12 N+4, events ignored
    11'b000_11111_001   // 13 stays idle
  };

  function automatic string tag_of(int k);
    case (k)
      0: return "R1";
      1, 3: return "R2";
      2: return "R6";
      4, 7: return "R5";
      5: return "R8";
      6: return "R7";
      8: return "R11";
      9: return "R3";
      10, 11: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {if_nop, id_nop, ex_nop, mem_nop, wb_nop, pc_we, ifid_hold, all_idle};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {3'b000, if_nop, id_nop, ex_nop, mem_nop, wb_nop}, 8'b0000_1111);
    rst = 1'b0;
    for (int k = 0; k < NVEC; k++) begin
      {halt_fetched, branch_taken, stall_req} = VEC[k][10:8];
      #0.5;
      check(tag_of(k), outs(), VEC[k][7:0]);
      @(negedge clk);
    end
    {halt_fetched, branch_taken, stall_req} = 3'b000;

    // R1: reset mid-run from the drained state
    rst = 1'b1;
    @(negedge clk);
    check("R1", outs(), 8'b01111_100);
    rst = 1'b0;
    @(negedge clk);  // state 00111
    // R9: halt together with a stall is dropped
    halt_fetched = 1'b1; stall_req = 1'b1;
    #0.5;
    check("R9", {6'b0, pc_we, ifid_hold}, 8'b0000_0001);
    @(negedge clk);
    stall_req = 1'b0;
    check("R9", {3'b000, if_nop, id_nop, ex_nop, mem_nop, wb_nop}, 8'b0000_0111);
    // R9: halt together with a taken branch is dropped
    branch_taken = 1'b1;
    #0.5;
    check("R9", {6'b0, pc_we, ifid_hold}, 8'b0000_0010);
    @(negedge clk);
    branch_taken = 1'b0;
    check("R9", {3'b000, if_nop, id_nop, ex_nop, mem_nop, wb_nop}, 8'b0000_1011);
    // R3: halt taken now closes fetch and decode next cycle
    @(negedge clk);
    halt_fetched = 1'b0;
    check("R3", {3'b000, if_nop, id_nop, ex_nop, mem_nop, wb_nop}, 8'b0001_1101);
    @(negedge clk);
    check("R3", {3'b000, if_nop, id_nop, ex_nop, mem_nop, wb_nop}, 8'b0001_1110);
    @(negedge clk);
    check("R10", {7'b0, all_idle}, 8'b0000_0001);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule